// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Trigger Interrupts

This block sits between a processor-facing register interface and the serial shifter of an SPI controller. It holds one byte FIFO for outgoing data and one for incoming data. Software, or a data mover, writes transmit bytes into one port and reads received bytes from another. The shifter side takes bytes out of the transmit FIFO and puts bytes into the receive FIFO through single-cycle strobes.

A control word sets a trigger level for each direction and holds a flush command for each FIFO. A flush command clears itself. A read-only word reports both fill levels. An interrupt status word collects sticky events: fill-level requests, empty and full, overflow and underflow on either side, and two event inputs from the rest of the controller (transfer finished, chip select released). Each status bit has an enable bit, and the single interrupt line is high when any enabled status bit is set.

The byte streams use valid/ready. The transmit input applies no back-pressure: `tx_in_ready` is always high. A byte offered while the FIFO is full is taken from the stream and discarded, and the overflow status records the loss. On the receive output, `rx_out_valid` shows that data is present. A ready pulse while valid is low is allowed: it counts as an underflow and returns zero.

Top module: `spi_fifo_irq`

## Requirements
- R1: Each FIFO holds DEPTH (default 64) bytes and returns them in the order they were written. The fill-level word at address 1 is read-only: it carries the TX count in bits 23:16 and the RX count in bits 7:0, and every other bit reads as 0.
- R2: `tx_in_ready` is always 1. A TX byte offered while the TX FIFO holds DEPTH bytes is dropped, the count stays at DEPTH, and status bit 10 (TX overflow) is set.
- R3: `rx_out_valid` is 1 exactly when the RX FIFO is not empty. `rx_out_data` shows the oldest byte, and reads 0 when the FIFO is empty. Asserting `rx_out_ready` while the FIFO is empty sets status bit 9 (RX underflow).
- R4: `sh_tx_pop` on an empty TX FIFO sets status bit 11 (TX underflow). `sh_rx_push` on a full RX FIFO drops the byte and sets status bit 8 (RX overflow).
- R5: The control word is at address 0. Bit 31 flushes TX, bits 23:16 hold the TX trigger, bit 15 flushes RX and bits 7:0 hold the RX trigger. A flush bit reads 1 for one cycle after the write. On the next clock it empties its FIFO and reads back 0. The trigger fields keep their values.
- R6: Status bit 4 (TX request) sets whenever the TX count is less than or equal to the TX trigger. Status bit 0 (RX ready) sets whenever the RX count is greater than or equal to the RX trigger.
- R7: Status bits 1 and 5 set while RX or TX, respectively, is empty. Bits 2 and 6 set while RX or TX, respectively, is full.
- R8: A pulse on `ev_xfer_done` sets status bit 12. A pulse on `ev_cs_release` sets status bit 13.
- R9: Status bits at address 3 are sticky and are computed one clock after the condition. Writing 1 to a bit clears it. If the condition still holds in the clearing cycle, setting wins and the bit stays 1.
- R10: The enable word is at address 2. `irq` is 1 exactly when some status bit and its enable bit are both 1. Unimplemented bits (3, 7 and 14 and above) of the enable and status words read as 0.
- R11: While `rst_n` is low, both FIFOs are empty, all four words read as 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 control, 1 fill levels, 2 enable, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| tx_in_valid | input | 1 | TX byte offered |
| tx_in_ready | output | 1 | Always 1; bytes offered while full are dropped |
| tx_in_data | input | DW | TX byte |
| sh_tx_pop | input | 1 | Shifter takes the oldest TX byte |
| sh_tx_data | output | DW | Oldest TX byte (0 when empty) |
| sh_rx_push | input | 1 | Shifter delivers an RX byte |
| sh_rx_data | input | DW | RX byte from the shifter |
| rx_out_valid | output | 1 | RX FIFO not empty |
| rx_out_ready | input | 1 | Consumer takes the oldest RX byte |
| rx_out_data | output | DW | Oldest RX byte (0 when empty) |
| ev_xfer_done | input | 1 | Transfer-complete event pulse |
| ev_cs_release | input | 1 | Chip-select release event pulse |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that every input is at a known value from the first clock after reset, and that a flush and a pop can coincide with an overflowing write. For this reason the overflow property excludes cycles with a same-cycle pop or flush rather than assuming they never happen. The stimulus changes inputs only just after a rising edge, so every strobe lasts exactly one cycle. It issues at most one register write per cycle, and it mixes full, empty and flush cases with random traffic. Because of this, the overflow, underflow and set-wins-over-clear paths are all reached while the assumptions still hold.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;
  localparam int FLD_W  = 8;
  localparam int STAT_W = 14;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_FILL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_ISTAT = 2'd3;

  localparam int B_RX_RDY  = 0;
  localparam int B_RX_EMP  = 1;
  localparam int B_RX_FULL = 2;
  localparam int B_TX_REQ  = 4;
  localparam int B_TX_EMP  = 5;
  localparam int B_TX_FULL = 6;
  localparam int B_RX_OVF  = 8;
  localparam int B_RX_UDF  = 9;
  localparam int B_TX_OVF  = 10;
  localparam int B_TX_UDF  = 11;
  localparam int B_DONE    = 12;
  localparam int B_CS_REL  = 13;

  localparam logic [STAT_W-1:0] STAT_MASK = 14'h3F77;

  typedef struct packed {
    logic             tx_rst;
    logic [FLD_W-1:0] tx_trig;
    logic             rx_rst;
    logic [FLD_W-1:0] rx_trig;
  } spf_ctrl_t;
endpackage

// File: rtl/spf_byte_fifo.sv
module spf_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/spf_regs.sv
module spf_regs
  import spf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [STAT_W-1:0] stat_set,
  input  logic [FLD_W-1:0]  tx_cnt_f,
  input  logic [FLD_W-1:0]  rx_cnt_f,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [FLD_W-1:0]  tx_trig,
  output logic [FLD_W-1:0]  rx_trig,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic [STAT_W-1:0] int_stat,
  output logic              irq
);
  spf_ctrl_t         ctrl_q;
  logic [STAT_W-1:0] ien_q;
  logic [STAT_W-1:0] clr;
  logic              wr_ctrl, wr_ien, wr_stat;
  logic              wdata_unused;

  assign wdata_unused = ^{reg_wdata[30:24], reg_wdata[14:8]};

  assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_ien  = reg_wr && (reg_addr == ADR_IEN);
  assign wr_stat = reg_wr && (reg_addr == ADR_ISTAT);
  assign clr     = wr_stat ? reg_wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      int_stat <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.tx_rst  <= reg_wdata[31];
        ctrl_q.tx_trig <= reg_wdata[23:16];
        ctrl_q.rx_rst  <= reg_wdata[15];
        ctrl_q.rx_trig <= reg_wdata[7:0];
      end else begin
        ctrl_q.tx_rst <= 1'b0;
        ctrl_q.rx_rst <= 1'b0;
      end
      if (wr_ien) ien_q <= reg_wdata[STAT_W-1:0] & STAT_MASK;
      int_stat <= ((int_stat & ~clr) | stat_set) & STAT_MASK;
    end
  end

  assign tx_trig  = ctrl_q.tx_trig;
  assign rx_trig  = ctrl_q.rx_trig;
  assign tx_flush = ctrl_q.tx_rst;
  assign rx_flush = ctrl_q.rx_rst;
  assign irq      = |(int_stat & ien_q);

  always_comb begin
    unique case (reg_addr)
      ADR_CTRL:  reg_rdata = {ctrl_q.tx_rst, 7'b0, ctrl_q.tx_trig,
                              ctrl_q.rx_rst, 7'b0, ctrl_q.rx_trig};
      ADR_FILL:  reg_rdata = {8'b0, tx_cnt_f, 8'b0, rx_cnt_f};
      ADR_IEN:   reg_rdata = {{(REG_W-STAT_W){1'b0}}, ien_q};
      default:   reg_rdata = {{(REG_W-STAT_W){1'b0}}, int_stat};
    endcase
  end
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DW-1:0]     tx_in_data,
  input  logic              sh_tx_pop,
  output logic [DW-1:0]     sh_tx_data,
  input  logic              sh_rx_push,
  input  logic [DW-1:0]     sh_rx_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DW-1:0]     rx_out_data,
  input  logic              ev_xfer_done,
  input  logic              ev_cs_release,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [FLD_W-1:0]  tx_cnt_f, rx_cnt_f, tx_trig, rx_trig;
  logic              tx_flush, rx_flush;
  logic [STAT_W-1:0] stat_set, int_stat;

  assign tx_in_ready = 1'b1;

  spf_byte_fifo #(.DEPTH(DEPTH), .W(DW), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_in_valid), .push_data(tx_in_data), .pop(sh_tx_pop),
    .head(sh_tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  spf_byte_fifo #(.DEPTH(DEPTH), .W(DW), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(sh_rx_push), .push_data(sh_rx_data), .pop(rx_out_ready),
    .head(rx_out_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign rx_out_valid = ~rx_empty;
  assign tx_cnt_f     = FLD_W'(tx_cnt);
  assign rx_cnt_f     = FLD_W'(rx_cnt);

  always_comb begin
    stat_set            = '0;
    stat_set[B_RX_RDY]  = rx_cnt_f >= rx_trig;
    stat_set[B_RX_EMP]  = rx_empty;
    stat_set[B_RX_FULL] = rx_full;
    stat_set[B_TX_REQ]  = tx_cnt_f <= tx_trig;
    stat_set[B_TX_EMP]  = tx_empty;
    stat_set[B_TX_FULL] = tx_full;
    stat_set[B_RX_OVF]  = sh_rx_push & rx_full;
    stat_set[B_RX_UDF]  = rx_out_ready & rx_empty;
    stat_set[B_TX_OVF]  = tx_in_valid & tx_full;
    stat_set[B_TX_UDF]  = sh_tx_pop & tx_empty;
    stat_set[B_DONE]    = ev_xfer_done;
    stat_set[B_CS_REL]  = ev_cs_release;
  end

  spf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat_set(stat_set),
    .tx_cnt_f(tx_cnt_f), .rx_cnt_f(rx_cnt_f), .reg_rdata(reg_rdata),
    .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .int_stat(int_stat), .irq(irq)
  );
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk
  import spf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wdata_txrst,
  input logic              tx_in_valid,
  input logic              sh_tx_pop,
  input logic              rx_out_ready,
  input logic              rx_out_valid,
  input logic [DW-1:0]     rx_out_data,
  input logic              ev_xfer_done,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              tx_flush,
  input logic [STAT_W-1:0] int_stat
);
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  a_r2_tx_overflow_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_cnt == CW'(DEPTH) && !sh_tx_pop && !tx_flush)
    |=> (tx_cnt == CW'(DEPTH)) && int_stat[B_TX_OVF]);

  a_r3_rx_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_ready && rx_cnt == '0) |=> int_stat[B_RX_UDF]);

  a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) |-> (!rx_out_valid && rx_out_data == '0));

  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_cnt == '0));

  a_r5_flush_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !(reg_wr && reg_addr == ADR_CTRL && wdata_txrst)) |=> !tx_flush);

  a_r8_done_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_done |=> int_stat[B_DONE]);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADR_ISTAT)
    |=> ((int_stat & $past(int_stat)) == $past(int_stat)));
endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wdata_txrst(reg_wdata[31]), .tx_in_valid(tx_in_valid),
  .sh_tx_pop(sh_tx_pop), .rx_out_ready(rx_out_ready),
  .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
  .ev_xfer_done(ev_xfer_done), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_flush(tx_flush), .int_stat(int_stat)
);

// File: tb/sim_spi_fifo_irq.sv
module sim_spi_fifo_irq;
  localparam int DEPTH = 64;
  localparam int MASK  = 'h3F77;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tx_in_valid, tx_in_ready;
  logic [7:0]  tx_in_data, sh_tx_data, sh_rx_data, rx_out_data;
  logic        sh_tx_pop, sh_rx_push, rx_out_valid, rx_out_ready;
  logic        ev_xfer_done, ev_cs_release, irq;

  always #10 clk = ~clk;

  spi_fifo_irq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
    .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .ev_xfer_done(ev_xfer_done), .ev_cs_release(ev_cs_release), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] tq[$];
  logic [7:0] rq[$];
  int stat_m = 0, en_m = 0, tx_trig_m = 0, rx_trig_m = 0;
  bit tx_pend_m = 0, rx_pend_m = 0;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    tx_in_valid = 0; tx_in_data = 0; sh_tx_pop = 0;
    sh_rx_push = 0; sh_rx_data = 0; rx_out_ready = 0;
    ev_xfer_done = 0; ev_cs_release = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_wr = 0; reg_addr = a; #1; v = reg_rdata;
  endtask

  function automatic int set_vec(int tc, int rc);
    int s = 0;
    if (rc >= rx_trig_m) s |= 1 << 0;
    if (rc == 0)         s |= 1 << 1;
    if (rc == DEPTH)     s |= 1 << 2;
    if (tc <= tx_trig_m) s |= 1 << 4;
    if (tc == 0)         s |= 1 << 5;
    if (tc == DEPTH)     s |= 1 << 6;
    if (sh_rx_push && rc == DEPTH)  s |= 1 << 8;
    if (rx_out_ready && rc == 0)    s |= 1 << 9;
    if (tx_in_valid && tc == DEPTH) s |= 1 << 10;
    if (sh_tx_pop && tc == 0)       s |= 1 << 11;
    if (ev_xfer_done)  s |= 1 << 12;
    if (ev_cs_release) s |= 1 << 13;
    return s;
  endfunction

  task automatic check_all();
    logic [31:0] v;
    rd(2'd1, v);
    chk("R1", int'(v), (tq.size() << 16) | rq.size(), "fill counts");
    rd(2'd3, v);
    chk("R9", int'(v), stat_m, "interrupt status");
    chk("R10", int'(irq), int'((stat_m & en_m) != 0), "irq line");
    chk("R3", int'(rx_out_valid), int'(rq.size() > 0), "rx valid");
    if (rq.size() == 0) chk("R3", int'(rx_out_data), 0, "empty rx data");
    chk("R2", int'(tx_in_ready), 1, "tx ready");
  endtask

  // One clock: update the reference from the inputs now applied, then compare.
  task automatic tick();
    int s, clr, tc, rc;
    bit tfl, rfl;
    tc = tq.size(); rc = rq.size();
    s = set_vec(tc, rc);
    clr = (reg_wr && reg_addr == 2'd3) ? int'(reg_wdata & 32'h3FFF) : 0;
    if (rx_out_ready && rc > 0) chk("R3", int'(rx_out_data), int'(rq[0]), "rx byte order");
    if (sh_tx_pop && tc > 0) chk("R1", int'(sh_tx_data), int'(tq[0]), "tx byte order");
    tfl = tx_pend_m; rfl = rx_pend_m;
    if (tfl) tq.delete();
    else begin
      if (sh_tx_pop && tc > 0) void'(tq.pop_front());
      if (tx_in_valid && tc < DEPTH) tq.push_back(tx_in_data);
    end
    if (rfl) rq.delete();
    else begin
      if (rx_out_ready && rc > 0) void'(rq.pop_front());
      if (sh_rx_push && rc < DEPTH) rq.push_back(sh_rx_data);
    end
    stat_m = ((stat_m & ~clr) | s) & MASK;
    if (reg_wr && reg_addr == 2'd0) begin
      tx_trig_m = int'(reg_wdata[23:16]); rx_trig_m = int'(reg_wdata[7:0]);
      tx_pend_m = reg_wdata[31]; rx_pend_m = reg_wdata[15];
    end else begin
      tx_pend_m = 0; rx_pend_m = 0;
    end
    if (reg_wr && reg_addr == 2'd2) en_m = int'(reg_wdata) & MASK;
    @(posedge clk); #1;
    check_all();
    idle_in();
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    idle_in(); reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'd20240607);
    idle_in();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R11", int'(v), 0, "word in reset");
    end
    chk("R11", int'(irq), 0, "irq in reset");
    chk("R11", int'(rx_out_valid), 0, "rx valid in reset");
    idle_in();
    rst_n = 1;

    // R7 / R6: empty FIFOs, zero triggers
    tick();
    rd(2'd3, v);
    chk("R7", int'(v), 'h33, "status after reset release");

    // R10: enables, unimplemented bits
    wreg(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v);
    chk("R10", int'(v), 'h3F77, "enable readback");
    chk("R10", int'(irq), 1, "irq with enables");

    // R9: set wins over clear while condition holds
    wreg(2'd3, 32'h0000_3F77);
    rd(2'd3, v);
    chk("R9", int'(v), 'h33, "clear while conditions hold");
    wreg(2'd0, 32'h0000_0005);
    wreg(2'd3, 32'h0000_0001);
    rd(2'd3, v);
    chk("R9", int'(v[0]), 0, "rx ready cleared");
    chk("R6", int'(v[4]), 1, "tx request at trigger");

    // R2: fill TX, then overflow
    for (int i = 0; i < DEPTH; i++) begin
      tx_in_valid = 1; tx_in_data = 8'(i * 3 + 1); tick();
    end
    tx_in_valid = 1; tx_in_data = 8'hEE; tick();
    tick();
    rd(2'd1, v);
    chk("R2", int'(v[23:16]), DEPTH, "tx count after overflow");
    rd(2'd3, v);
    chk("R2", int'(v[10]), 1, "tx overflow bit");
    chk("R7", int'(v[6]), 1, "tx full bit");
    // R4: drain in order, then underflow
    for (int i = 0; i < DEPTH; i++) begin
      sh_tx_pop = 1; tick();
    end
    sh_tx_pop = 1; tick();
    tick();
    rd(2'd3, v);
    chk("R4", int'(v[11]), 1, "tx underflow bit");

    // R4: RX overflow
    for (int i = 0; i < DEPTH; i++) begin
      sh_rx_push = 1; sh_rx_data = 8'(255 - i); tick();
    end
    sh_rx_push = 1; sh_rx_data = 8'h5A; tick();
    tick();
    rd(2'd3, v);
    chk("R4", int'(v[8]), 1, "rx overflow bit");
    chk("R7", int'(v[2]), 1, "rx full bit");
    chk("R6", int'(v[0]), 1, "rx ready above trigger");
    for (int i = 0; i < DEPTH; i++) begin
      rx_out_ready = 1; tick();
    end
    // R3: read empty
    rx_out_ready = 1;
    chk("R3", int'(rx_out_data), 0, "data when empty");
    tick();
    tick();
    rd(2'd3, v);
    chk("R3", int'(v[9]), 1, "rx underflow bit");

    // R5: self-clearing flush
    for (int i = 0; i < 3; i++) begin
      tx_in_valid = 1; tx_in_data = 8'(i); sh_rx_push = 1; sh_rx_data = 8'(i); tick();
    end
    wreg(2'd0, 32'h8030_8010);
    rd(2'd0, v);
    chk("R5", int'(v), 32'h8030_8010, "flush bits visible");
    tick();
    rd(2'd0, v);
    chk("R5", int'(v), 32'h0030_0010, "flush bits cleared");
    rd(2'd1, v);
    chk("R5", int'(v), 0, "fifos flushed");

    // R8: event inputs
    wreg(2'd3, 32'h0000_3F77);
    ev_xfer_done = 1; tick();
    rd(2'd3, v);
    chk("R8", int'(v[12]), 1, "transfer done bit");
    chk("R8", int'(v[13]), 0, "cs bit still clear");
    ev_cs_release = 1; tick();
    rd(2'd3, v);
    chk("R8", int'(v[13]), 1, "cs release bit");

    // R6: TX request above trigger stays clear
    wreg(2'd0, 32'h0002_0002);
    for (int i = 0; i < 3; i++) begin
      tx_in_valid = 1; tx_in_data = 8'(i); tick();
    end
    wreg(2'd3, 32'h0000_0010);
    tick();
    rd(2'd3, v);
    chk("R6", int'(v[4]), 0, "tx request above trigger");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      tx_in_valid  = ($urandom_range(0, 99) < 45);
      tx_in_data   = 8'($urandom_range(0, 255));
      sh_tx_pop    = ($urandom_range(0, 99) < 40);
      sh_rx_push   = ($urandom_range(0, 99) < 45);
      sh_rx_data   = 8'($urandom_range(0, 255));
      rx_out_ready = ($urandom_range(0, 99) < 40);
      ev_xfer_done  = ($urandom_range(0, 15) == 0);
      ev_cs_release = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 5) == 0) begin
        reg_wr   = 1;
        reg_addr = 2'($urandom_range(0, 3));
        reg_wdata = $urandom();
        if (reg_addr == 2'd0) begin
          if ($urandom_range(0, 3) != 0) reg_wdata[31] = 1'b0;
          if ($urandom_range(0, 3) != 0) reg_wdata[15] = 1'b0;
          reg_wdata[23:16] = 8'($urandom_range(0, 70));
          reg_wdata[7:0]   = 8'($urandom_range(0, 70));
        end
      end
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule